// File: doc/BRIEF.md
# Embedded Trace Recorder with Delta Time Stamps

This block is an on-chip logic analyser. Once armed, it watches a wide probe bus and writes a frame into a small memory each time the bus changes value. Each stored frame carries a count of the idle cycles since the previous stored frame. Because quiet stretches cost no storage, a shallow memory can cover a long window of activity.

A host controls the block through one 64-bit command word and reads results from one 64-bit read register. A command can set a delay before recording starts or a delay before it stops. Other commands select what the next reads return: the status, the frame geometry, the start offset or the stored trace.

The trace is returned as a stream. Each frame gives one delta word, followed by that frame's probe payload cut into 64-bit words.

Top module: `trc_scope`

## Requirements
- R1: A command write carries its opcode in `cmd_data[2:0]` and its argument in `cmd_data[63:3]`. Opcodes are 0 status, 1 trace data, 2 frame width, 3 frame count, 4 start delay, 5 stop delay and 6 start offset. Opcode 7 changes nothing: it does not alter the selected read mode, the recorder state or the readout position.
- R2: Opcode 4 with argument N clears any earlier recording and arms the recorder. The first frame is sampled at the N+2nd rising edge after the edge that accepted the command, and it stores delta 0. Opcode 6 then reads back N.
- R3: While recording, a frame is stored on any edge where the probe differs from the last stored frame. A frame is also stored when the delta counter has reached all ones (2^DELTA_W-1). A stored delta D means D+1 cycles passed since the previous frame.
- R4: Recording ends by itself after DEPTH frames have been stored.
- R5: Opcode 5 with argument S arms the stop timer, which counts down only while recording. Recording ends on the S+1st recording edge after the timer is loaded, provided at least one frame exists by then, and no frame is stored on that edge.
- R6: The status read returns 1 once recording has ended while unread frames remain. It returns 0 while idle, while armed or recording, and after the last payload word has been read.
- R7: The width read returns PROBE_W. The count read returns the number of frames stored.
- R8: After opcode 1, each read returns one delta word (zero-extended), then ceil(PROBE_W/64) payload words for that frame. Probe bit i sits at word i/64, bit i%64, and the padding bits are zero. The stream then moves to the next frame. No delta word follows the final frame, and reads after the final frame return 0.
- R9: Sending opcode 0 and then opcode 1 again partway through a readout leaves the readout position unchanged.
- R10: Reads while armed or recording return 0. `rd_data` changes only on the edge that samples `rd_strobe`, so a value is visible the cycle after the strobe.
- R11: After reset the recorder is idle, `rd_data` is 0, and the status and count reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe | input | PROBE_W | Probe bus being recorded |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 64 | Command word: opcode [2:0], argument [63:3] |
| rd_strobe | input | 1 | Read strobe; advances the trace stream |
| rd_data | output | 64 | Registered read result |

## Verification
The probe is driven in four patterns, each with its own purpose:
- Random values held for a few cycles exercise mixed delta values and termination by the stop timer.
- A value that changes on every edge separates change detection from memory-full termination and checks delta 0.
- A bus held constant for hundreds of cycles isolates the saturation frames that carry the all-ones delta.
- A fully random run with random delays covers start offsets.

In every pattern, the full delta and payload stream is compared against a frame list built by a cycle model of the requirements. Status and data are re-issued just before the last frame to expose any pointer disturbance.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        OP_VALID  = 3'd0,
        OP_DATA   = 3'd1,
        OP_WIDTH  = 3'd2,
        OP_COUNT  = 3'd3,
        OP_START  = 3'd4,
        OP_STOP   = 3'd5,
        OP_OFFSET = 3'd6,
        OP_RSVD   = 3'd7
    } trc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CAP,
        ST_DONE
    } trc_state_e;

    function automatic int words_for(int bits);
        return (bits + WORD_W - 1) / WORD_W;
    endfunction

endpackage

// File: rtl/trc_arm.sv
module trc_arm
    import trc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  trc_op_e          op,
    input  logic [CNT_W-1:0] arg,
    input  logic             frames_nz,
    input  logic             full_now,
    output trc_state_e       state,
    output logic             start_cmd,
    output logic             stop_now,
    output logic [CNT_W-1:0] offset
);

    logic [CNT_W-1:0] dly_q;
    logic [CNT_W-1:0] stop_q;
    logic             stop_arm_q;
    logic             stop_cmd;

    assign start_cmd = cmd_wr && (op == OP_START);
    assign stop_cmd  = cmd_wr && (op == OP_STOP);
    assign stop_now  = (state == ST_CAP) && stop_arm_q && (stop_q == '0) && frames_nz;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dly_q      <= '0;
            stop_q     <= '0;
            stop_arm_q <= 1'b0;
            offset     <= '0;
        end else if (start_cmd) begin
            state      <= ST_WAIT;
            dly_q      <= arg;
            offset     <= arg;
            stop_arm_q <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (dly_q == '0) state <= ST_CAP;
                    else             dly_q <= dly_q - 1'b1;
                end
                ST_CAP: begin
                    if (stop_now || full_now)             state  <= ST_DONE;
                    else if (stop_arm_q && stop_q != '0)  stop_q <= stop_q - 1'b1;
                end
                default: ;
            endcase
            if (stop_cmd) begin
                stop_arm_q <= 1'b1;
                stop_q     <= arg;
            end
        end
    end

    // R2: an accepted start command always leads to the waiting state
    p_arm_wait_r2: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> state == ST_WAIT);

    // R4/R5: a finished recording stays finished until re-armed
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) && !start_cmd |=> state == ST_DONE);

endmodule

// File: rtl/trc_capture.sv
module trc_capture
    import trc_pkg::*;
#(
    parameter int PROBE_W = 72,
    parameter int DELTA_W = 8,
    parameter int DEPTH   = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int IDX_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               en,
    input  logic [PROBE_W-1:0] probe,
    input  logic [AW-1:0]      rd_idx,
    output logic               full_now,
    output logic [IDX_W-1:0]   count,
    output logic [PROBE_W-1:0] rd_probe,
    output logic [DELTA_W-1:0] rd_delta
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(DEPTH);

    logic [PROBE_W-1:0] probe_mem [DEPTH];
    logic [DELTA_W-1:0] delta_mem [DEPTH];
    logic [PROBE_W-1:0] last_q;
    logic [DELTA_W-1:0] delta_q;
    logic               store;

    assign store    = en && ((count == '0) || (probe != last_q) || (&delta_q));
    assign full_now = store && (count == LAST_IDX);
    assign rd_probe = probe_mem[rd_idx];
    assign rd_delta = delta_mem[rd_idx];

    always_ff @(posedge clk) begin
        if (store) begin
            probe_mem[count[AW-1:0]] <= probe;
            delta_mem[count[AW-1:0]] <= delta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count   <= '0;
            delta_q <= '0;
            last_q  <= '0;
        end else if (store) begin
            count   <= count + 1'b1;
            delta_q <= '0;
            last_q  <= probe;
        end else if (en) begin
            delta_q <= delta_q + 1'b1;
        end
    end

    // R4: the frame count never passes the memory depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R3: nothing is stored outside a recording window
    p_store_only_cap_r3: assert property (@(posedge clk) disable iff (rst)
        !en && !clear |=> $stable(count));

endmodule

// File: rtl/trc_readout.sv
module trc_readout
    import trc_pkg::*;
#(
    parameter int PROBE_W = 72,
    parameter int DELTA_W = 8,
    parameter int DEPTH   = 16,
    parameter int CNT_W   = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int IDX_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               cmd_wr,
    input  trc_op_e            op,
    input  trc_state_e         state,
    input  logic [IDX_W-1:0]   count,
    input  logic [CNT_W-1:0]   offset,
    input  logic               rd_strobe,
    input  logic [PROBE_W-1:0] rd_probe,
    input  logic [DELTA_W-1:0] rd_delta,
    output logic [AW-1:0]      rd_idx,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int NW    = words_for(PROBE_W);
    localparam int PAD_W = NW * WORD_W;
    localparam int WI_W  = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [WI_W-1:0] LAST_W = WI_W'(NW - 1);

    trc_op_e          mode_q;
    logic             in_pay_q;
    logic [WI_W-1:0]  wi_q;
    logic [IDX_W-1:0] fi_q;
    logic [PAD_W-1:0] padded;
    logic [WORD_W-1:0] word;
    logic             busy;
    logic             frames_left;
    logic             is_query;

    assign padded      = PAD_W'(rd_probe);
    assign word        = padded[wi_q * WORD_W +: WORD_W];
    assign busy        = (state == ST_WAIT) || (state == ST_CAP);
    assign frames_left = (state == ST_DONE) && (fi_q != count);
    assign is_query    = (op == OP_VALID) || (op == OP_DATA) || (op == OP_WIDTH)
                      || (op == OP_COUNT) || (op == OP_OFFSET);
    assign rd_idx      = fi_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= OP_VALID;
            rd_data  <= '0;
            fi_q     <= '0;
            wi_q     <= '0;
            in_pay_q <= 1'b0;
        end else begin
            if (cmd_wr && is_query) mode_q <= op;
            if (rd_strobe) begin
                if (busy) begin
                    rd_data <= '0;
                end else begin
                    case (mode_q)
                        OP_VALID:  rd_data <= {{(WORD_W-1){1'b0}}, frames_left};
                        OP_WIDTH:  rd_data <= WORD_W'(PROBE_W);
                        OP_COUNT:  rd_data <= WORD_W'(count);
                        OP_OFFSET: rd_data <= WORD_W'(offset);
                        OP_DATA: begin
                            if (!frames_left) begin
                                rd_data <= '0;
                            end else if (!in_pay_q) begin
                                rd_data  <= WORD_W'(rd_delta);
                                in_pay_q <= 1'b1;
                                wi_q     <= '0;
                            end else begin
                                rd_data <= word;
                                if (wi_q == LAST_W) begin
                                    in_pay_q <= 1'b0;
                                    fi_q     <= fi_q + 1'b1;
                                end else begin
                                    wi_q <= wi_q + 1'b1;
                                end
                            end
                        end
                        default: rd_data <= '0;
                    endcase
                end
            end
            if (clear) begin
                fi_q     <= '0;
                wi_q     <= '0;
                in_pay_q <= 1'b0;
            end
        end
    end

    // R10: reads while armed or recording yield zero
    p_quiet_busy_r10: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && busy |=> rd_data == '0);

    // R9: the stream position moves only on a read strobe or a new arming
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe && !clear |=> $stable(fi_q) && $stable(in_pay_q) && $stable(wi_q));

endmodule

// File: rtl/trc_scope.sv
module trc_scope
    import trc_pkg::*;
#(
    parameter int PROBE_W = 72,
    parameter int DEPTH   = 16,
    parameter int DELTA_W = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PROBE_W-1:0] probe,
    input  logic               cmd_wr,
    input  logic [63:0]        cmd_data,
    input  logic               rd_strobe,
    output logic [63:0]        rd_data
);

    localparam int AW    = $clog2(DEPTH);
    localparam int IDX_W = $clog2(DEPTH + 1);

    trc_op_e            op;
    logic [CNT_W-1:0]   arg;
    logic               unused_cmd_hi;
    trc_state_e         state;
    logic               start_cmd;
    logic               stop_now;
    logic [CNT_W-1:0]   offset;
    logic               full_now;
    logic [IDX_W-1:0]   count;
    logic [AW-1:0]      rd_idx;
    logic [PROBE_W-1:0] rd_probe;
    logic [DELTA_W-1:0] rd_delta;
    logic               cap_en;

    assign op            = trc_op_e'(cmd_data[2:0]);
    assign arg           = cmd_data[CNT_W+2:3];
    assign unused_cmd_hi = ^cmd_data[63:CNT_W+3];
    assign cap_en        = (state == ST_CAP) && !stop_now;

    trc_arm #(.CNT_W(CNT_W)) u_arm (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .op        (op),
        .arg       (arg),
        .frames_nz (count != '0),
        .full_now  (full_now),
        .state     (state),
        .start_cmd (start_cmd),
        .stop_now  (stop_now),
        .offset    (offset)
    );

    trc_capture #(.PROBE_W(PROBE_W), .DELTA_W(DELTA_W), .DEPTH(DEPTH)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_cmd),
        .en       (cap_en),
        .probe    (probe),
        .rd_idx   (rd_idx),
        .full_now (full_now),
        .count    (count),
        .rd_probe (rd_probe),
        .rd_delta (rd_delta)
    );

    trc_readout #(.PROBE_W(PROBE_W), .DELTA_W(DELTA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_cmd),
        .cmd_wr    (cmd_wr),
        .op        (op),
        .state     (state),
        .count     (count),
        .offset    (offset),
        .rd_strobe (rd_strobe),
        .rd_probe  (rd_probe),
        .rd_delta  (rd_delta),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/tb_trc_scope.sv
module tb_trc_scope;

    localparam int PW  = 72;
    localparam int DEP = 16;
    localparam int DW  = 8;
    localparam int NW  = (PW + 63) / 64;
    localparam int SAT = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] probe = '0;
    logic          cmd_wr = 1'b0;
    logic [63:0]   cmd_data = '0;
    logic          rd_strobe = 1'b0;
    logic [63:0]   rd_data;

    trc_scope #(.PROBE_W(PW), .DEPTH(DEP), .DELTA_W(DW), .CNT_W(32)) dut (
        .clk(clk), .rst(rst), .probe(probe), .cmd_wr(cmd_wr),
        .cmd_data(cmd_data), .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // cycle model of the requirements
    int            mst;
    longint        mcnt, mscnt, moff;
    bit            marm;
    int            mn, mdelta;
    logic [PW-1:0] mlast;
    logic [PW-1:0] mprobe [DEP];
    int            mdel [DEP];

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mn = 0; marm = 0; mscnt = 0; mcnt = 0; mdelta = 0; moff = 0; mlast = '0;
        end else begin
            if (cmd_wr && cmd_data[2:0] == 3'd4) begin
                mst = 1; mcnt = longint'(cmd_data[34:3]); moff = mcnt;
                mn = 0; marm = 0; mdelta = 0;
            end else begin
                if (mst == 1) begin
                    if (mcnt == 0) mst = 2; else mcnt--;
                end else if (mst == 2) begin
                    if (marm && mscnt == 0 && mn != 0) mst = 3;
                    else begin
                        if (marm && mscnt != 0) mscnt--;
                        if (mn == 0 || probe != mlast || mdelta == SAT) begin
                            mprobe[mn] = probe; mdel[mn] = mdelta;
                            mlast = probe; mdelta = 0; mn++;
                            if (mn == DEP) mst = 3;
                        end else mdelta++;
                    end
                end
                if (cmd_wr && cmd_data[2:0] == 3'd5) begin
                    marm = 1; mscnt = longint'(cmd_data[34:3]);
                end
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    bit auto_probe = 0;
    int hmin = 1, hmax = 1, hold_left = 0;

    task automatic tick();
        @(negedge clk);
        if (auto_probe) begin
            if (hold_left <= 1) begin
                probe = probe + PW'(1 + ($urandom % 1000));
                hold_left = hmin + int'($urandom % (hmax - hmin + 1));
            end else hold_left--;
        end
    endtask

    task automatic cmd(int op, longint arg);
        cmd_data = {arg[60:0], op[2:0]};
        cmd_wr = 1'b1;
        tick();
        cmd_wr = 1'b0;
    endtask

    task automatic rd(output logic [63:0] v);
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        v = rd_data;
    endtask

    task automatic query(int op, output logic [63:0] v);
        cmd(op, 0);
        rd(v);
    endtask

    task automatic wait_done();
        for (int g = 0; g < 5000 && mst != 3; g++) tick();
    endtask

    task automatic check_stream(string tag);
        logic [63:0] v;
        logic [NW*64-1:0] pad;
        query(0, v); chk({"R6 status ", tag}, v, 64'd1);
        query(3, v); chk({"R7 count ", tag}, v, 64'(mn));
        query(6, v); chk({"R2 offset ", tag}, v, 64'(moff));
        cmd(1, 0);
        for (int f = 0; f < mn; f++) begin
            if (f == mn - 1 && mn > 1) begin
                query(0, v); chk({"R9 status before last ", tag}, v, 64'd1);
                cmd(1, 0);
            end
            rd(v); chk({"R3 R8 delta ", tag}, v, 64'(mdel[f]));
            pad = (NW*64)'(mprobe[f]);
            for (int w = 0; w < NW; w++) begin
                rd(v); chk({"R8 payload ", tag}, v, pad[w*64 +: 64]);
            end
        end
        rd(v); chk({"R8 past end ", tag}, v, 64'd0);
        query(0, v); chk({"R6 status drained ", tag}, v, 64'd0);
    endtask

    initial begin
        logic [63:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        chk("R11 rd_data after reset", rd_data, 64'd0);
        query(0, v); chk("R11 status idle", v, 64'd0);
        query(3, v); chk("R11 count idle", v, 64'd0);
        query(2, v); chk("R7 width", v, 64'(PW));

        // run A: random holds, stop timer
        auto_probe = 1; hmin = 2; hmax = 6;
        cmd(4, 3);
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        chk("R10 read while armed", rd_data, 64'd0);
        cmd(5, 20);
        wait_done();
        chk("R5 ended by stop timer", 64'(mn < DEP), 64'd1);
        auto_probe = 0;
        check_stream("A");

        // run B: change every edge, memory full
        auto_probe = 1; hmin = 1; hmax = 1;
        cmd(4, 0);
        wait_done();
        auto_probe = 0;
        query(3, v); chk("R4 full count", v, 64'(DEP));
        check_stream("B");

        // run C: constant probe, saturating delta
        cmd(4, 5);
        cmd(5, 600);
        wait_done();
        query(3, v); chk("R5 stop frames", v, 64'd3);
        chk("R3 saturation delta", 64'(mdel[1]), 64'(SAT));
        query(3, v);
        cmd(7, 9);
        rd(v); chk("R1 opcode 7 keeps mode", v, 64'd3);
        check_stream("C");

        // run D: fully random
        auto_probe = 1; hmin = 1; hmax = 8;
        cmd(4, longint'($urandom % 8));
        cmd(5, longint'(10 + $urandom % 50));
        wait_done();
        auto_probe = 0;
        check_stream("D");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule